// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block is a purely combinational priority encoder. It is built from eight-line slices, and every input and output is active low. A slice watches eight request lines. When it is enabled, it reports three things: the position of the highest-numbered request that is pulled LOW, a flag showing that at least one of its requests is active, and an enable-out signal. Enable-out goes LOW only when the slice is enabled and all of its lines are idle.

The top level chains `N_SLICES` slices, from one to eight. The enable-out of each slice feeds the enable input of the next lower slice. A lower slice therefore takes part only when every higher line is idle. The wide code is assembled from two sources. The group flags of the slices supply the upper bits, which select the slice. The bitwise AND of the slices' three-bit codes supplies the low bits. This AND is safe because every slice that is not the winner drives all ones.

Top module: `prienc_cascade`

## Requirements
- R1: Request line `i` is active when `req_n[i]` is 0. Line 7 of a slice has the highest priority. With one slice enabled and lines active, `code_n` is the bitwise inverse of the highest active line number: line 7 alone gives 3'b000, and line 0 alone gives 3'b111.
- R2: When `en_n` is 1, `code_n`, `grp_n` and `eo_n` are all ones, whatever the request lines carry.
- R3: When `en_n` is 0 and at least one request line is 0, `grp_n` is 0 and `eo_n` is 1.
- R4: When `en_n` is 0 and every request line is 1, `eo_n` is 0, `grp_n` is 1 and `code_n` is all ones.
- R5: With several slices, line `i` of the whole vector has priority over every line below it. When enabled, `code_n` equals the inverse of the global index of the highest active line, and the upper bits encode the slice number.
- R6: The top `grp_n` is 0 exactly when some slice reports activity. The top `eo_n` is the enable-out of slice 0, the lowest slice, so it is 0 only when the block is enabled and all lines are idle.
- R7: `code_n` is `3 + clog2(N_SLICES)` bits wide, or 3 bits when `N_SLICES` is 1. At most one slice ever reports activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 8*N_SLICES | Active-low request lines; a higher index has higher priority |
| en_n | input | 1 | Active-low enable for the whole chain |
| code_n | output | 3+clog2(N_SLICES) | Active-low index of the highest active line |
| grp_n | output | 1 | Active-low: some request line is active |
| eo_n | output | 1 | Active-low: block enabled and every line idle |

## Verification
The bench builds three copies of the block. The first uses `N_SLICES = 2`. It is driven with all 2^17 combinations of request lines and enable, so every priority overlap across the slice boundary is reached. The second uses `N_SLICES = 1` and is driven exhaustively over 512 vectors, which covers the bare slice and the narrow three-bit code. The third uses `N_SLICES = 8`. It gets directed single-line vectors on all 64 lines and seeded random sparse vectors, which exercise a six-bit code and a chain eight slices deep.

// File: rtl/prienc_pkg.sv
package prienc_pkg;

    localparam int unsigned LINES_PER_SLICE = 8;
    localparam int unsigned SLICE_CODE_W    = 3;
    localparam int unsigned MAX_SLICES      = 8;

    typedef struct packed {
        logic [SLICE_CODE_W-1:0] code_n;
        logic                    grp_n;
        logic                    eo_n;
    } slice_out_t;

    localparam slice_out_t SLICE_IDLE = '{code_n: '1, grp_n: 1'b1, eo_n: 1'b1};

    function automatic int unsigned sel_bits(input int unsigned n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

    function automatic int unsigned wide_code_w(input int unsigned n);
        return SLICE_CODE_W + sel_bits(n);
    endfunction

endpackage

// File: rtl/prienc_slice.sv
module prienc_slice
    import prienc_pkg::*;
(
    input  logic [LINES_PER_SLICE-1:0] req_n,
    input  logic                       en_n,
    output logic [SLICE_CODE_W-1:0]    code_n,
    output logic                       grp_n,
    output logic                       eo_n
);

    slice_out_t res;

    always_comb begin
        res = SLICE_IDLE;
        if (!en_n) begin
            if (&req_n) begin
                res.eo_n = 1'b0;
            end else begin
                res.grp_n = 1'b0;
                for (int i = 0; i < LINES_PER_SLICE; i++) begin
                    if (!req_n[i]) res.code_n = ~SLICE_CODE_W'(i);
                end
            end
        end
    end

    assign code_n = res.code_n;
    assign grp_n  = res.grp_n;
    assign eo_n   = res.eo_n;

    always_comb begin
        if (!$isunknown({req_n, en_n})) begin
            AST_DISABLED_QUIET: assert (!en_n || (&code_n && grp_n && eo_n))
                else $error("slice drives outputs while disabled"); // R2
            AST_GRP_EO_EXCLUSIVE: assert (grp_n || eo_n)
                else $error("slice reports activity and idle together"); // R3
            AST_IDLE_CODE_HIGH: assert (!grp_n || &code_n)
                else $error("slice code active without group flag"); // R4
        end
    end

endmodule

// File: rtl/prienc_merge.sv
module prienc_merge
    import prienc_pkg::*;
#(
    parameter int unsigned N_SLICES = 2,
    localparam int unsigned SEL_W   = sel_bits(N_SLICES),
    localparam int unsigned OUT_W   = wide_code_w(N_SLICES)
) (
    input  logic [N_SLICES*SLICE_CODE_W-1:0] slice_code_n,
    input  logic [N_SLICES-1:0]              slice_grp_n,
    output logic [OUT_W-1:0]                 code_n,
    output logic                             grp_n
);

    logic [SLICE_CODE_W-1:0] low_code_n;

    always_comb begin
        low_code_n = '1;
        for (int k = 0; k < N_SLICES; k++) begin
            low_code_n &= slice_code_n[k*SLICE_CODE_W +: SLICE_CODE_W];
        end
    end

    assign code_n[SLICE_CODE_W-1:0] = low_code_n;
    assign grp_n = &slice_grp_n;

    generate
        for (genvar j = 0; j < SEL_W; j++) begin : g_sel_bit
            logic bit_n;
            always_comb begin
                bit_n = 1'b1;
                for (int k = 0; k < N_SLICES; k++) begin
                    if (((k >> j) & 1) == 1) bit_n &= slice_grp_n[k];
                end
            end
            assign code_n[SLICE_CODE_W + j] = bit_n;
        end
    endgenerate

    always_comb begin
        if (!$isunknown(slice_grp_n)) begin
            AST_SINGLE_WINNER: assert ($countones(~slice_grp_n) <= 1)
                else $error("more than one slice active"); // R7
        end
        if (!$isunknown({slice_grp_n, code_n})) begin
            AST_NO_WINNER_CODE_HIGH: assert (!grp_n || &code_n)
                else $error("wide code active with no winner"); // R6
        end
    end

endmodule

// File: rtl/prienc_cascade.sv
module prienc_cascade
    import prienc_pkg::*;
#(
    parameter int unsigned N_SLICES = 2,
    localparam int unsigned LINES   = N_SLICES * LINES_PER_SLICE,
    localparam int unsigned OUT_W   = wide_code_w(N_SLICES)
) (
    input  logic [LINES-1:0] req_n,
    input  logic             en_n,
    output logic [OUT_W-1:0] code_n,
    output logic             grp_n,
    output logic             eo_n
);

    logic [N_SLICES:0]                chain_en_n;
    logic [N_SLICES*SLICE_CODE_W-1:0] s_code_n;
    logic [N_SLICES-1:0]              s_grp_n;

    assign chain_en_n[N_SLICES] = en_n;

    generate
        for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
            prienc_slice u_slice (
                .req_n  (req_n[k*LINES_PER_SLICE +: LINES_PER_SLICE]),
                .en_n   (chain_en_n[k+1]),
                .code_n (s_code_n[k*SLICE_CODE_W +: SLICE_CODE_W]),
                .grp_n  (s_grp_n[k]),
                .eo_n   (chain_en_n[k])
            );
        end
    endgenerate

    prienc_merge #(.N_SLICES(N_SLICES)) u_merge (
        .slice_code_n (s_code_n),
        .slice_grp_n  (s_grp_n),
        .code_n       (code_n),
        .grp_n        (grp_n)
    );

    assign eo_n = chain_en_n[0];

    always_comb begin
        if (!$isunknown({req_n, en_n})) begin
            AST_EO_MEANS_ALL_IDLE: assert (eo_n || (!en_n && &req_n))
                else $error("chain idle flag with a live request"); // R6
            AST_GRP_OR_EO_WHEN_ON: assert (en_n || (grp_n != eo_n))
                else $error("enabled chain neither active nor idle"); // R5
        end
    end

endmodule

// File: tb/prienc_cascade_bench.sv
module prienc_cascade_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] req2 = '1;  logic en2 = 1'b1;
    logic [3:0]  code2;      logic grp2, eo2;
    logic [7:0]  req1 = '1;  logic en1 = 1'b1;
    logic [2:0]  code1;      logic grp1, eo1;
    logic [63:0] req8 = '1;  logic en8 = 1'b1;
    logic [5:0]  code8;      logic grp8, eo8;

    prienc_cascade #(.N_SLICES(2)) u_prienc_cascade (
        .req_n(req2), .en_n(en2), .code_n(code2), .grp_n(grp2), .eo_n(eo2));
    prienc_cascade #(.N_SLICES(1)) u_prienc_cascade_one (
        .req_n(req1), .en_n(en1), .code_n(code1), .grp_n(grp1), .eo_n(eo1));
    prienc_cascade #(.N_SLICES(8)) u_prienc_cascade_wide (
        .req_n(req8), .en_n(en8), .code_n(code8), .grp_n(grp8), .eo_n(eo8));

    // reference: returns {code_n[5:0], grp_n, eo_n}; code bits above width are 1
    function automatic logic [7:0] ref_enc(input logic [63:0] rq, input logic en,
                                           input int lines);
        logic [5:0] c = '1;
        logic g = 1'b1;
        logic e = 1'b1;
        if (!en) begin
            e = 1'b0;
            for (int i = 0; i < lines; i++) begin
                if (!rq[i]) begin
                    c = ~6'(i);
                    g = 1'b0;
                    e = 1'b1;
                end
            end
        end
        return {c, g, e};
    endfunction

    function automatic int code_w(input int n);
        return (n <= 1) ? 3 : 3 + $clog2(n);
    endfunction

    task automatic one(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic chk(input int n, input logic [63:0] rq, input logic en,
                       input logic [5:0] code, input logic grp, input logic eo);
        logic [7:0] exp;
        logic [5:0] mask;
        bit idle;
        exp  = ref_enc(rq, en, n * 8);
        mask = 6'((64'd1 << code_w(n)) - 1);
        idle = 1'b1;
        for (int i = 0; i < n * 8; i++) if (!rq[i]) idle = 1'b0;
        if (en) begin
            one("R2 disabled outputs", {code | ~mask, grp, eo}, {6'h3f, 2'b11});
        end else if (idle) begin
            one("R4 idle outputs", {2'b00, code & mask, grp, eo},
                {2'b00, exp[7:2] & mask, exp[1:0]});
        end else begin
            one(n == 1 ? "R1 slice code" : "R5 cascaded code",
                {2'b00, code & mask}, {2'b00, exp[7:2] & mask});
            one(n == 1 ? "R3 group flag" : "R6 group and chain out",
                {6'd0, grp, eo}, {6'd0, exp[1:0]});
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        #3;
        // reset state: all disabled, all quiet
        chk(2, {48'hffff_ffff_ffff, req2}, en2, {2'b11, code2}, grp2, eo2);
        chk(8, req8, en8, code8, grp8, eo8);
        // R7: output widths
        one("R7 width one slice", 8'($bits(code1)), 8'd3);
        one("R7 width two slices", 8'($bits(code2)), 8'd4);
        one("R7 width eight slices", 8'($bits(code8)), 8'd6);

        // R1 directed corner cases on a single slice
        req1 = 8'h7f; en1 = 1'b0; #1;
        one("R1 line7 gives 000", {5'd0, code1}, 8'd0);
        req1 = 8'hfe; #1;
        one("R1 line0 gives 111", {5'd0, code1}, 8'd7);
        req1 = 8'h00; #1;
        one("R1 all lines active", {5'd0, code1}, 8'd0);

        // exhaustive single slice (R1, R2, R3, R4, R7)
        for (int v = 0; v < 512; v++) begin
            {en1, req1} = 9'(v);
            #1;
            chk(1, {56'hff_ffff_ffff_ffff, req1}, en1, {3'b111, code1}, grp1, eo1);
            #1;
        end

        // exhaustive two slices (R5, R6)
        for (int v = 0; v < (1 << 17); v++) begin
            {en2, req2} = 17'(v);
            #1;
            chk(2, {48'hffff_ffff_ffff, req2}, en2, {2'b11, code2}, grp2, eo2);
            #1;
        end

        // eight slices: each single line, then boundary pairs (R5)
        en8 = 1'b0;
        for (int i = 0; i < 64; i++) begin
            req8 = ~(64'd1 << i);
            #1;
            chk(8, req8, en8, code8, grp8, eo8);
            #1;
        end
        req8 = ~(64'd1 | (64'd1 << 63)); #1; chk(8, req8, en8, code8, grp8, eo8); #1;
        req8 = '1; #1; chk(8, req8, en8, code8, grp8, eo8); #1;           // R4
        en8 = 1'b1; req8 = '0; #1; chk(8, req8, en8, code8, grp8, eo8); #1; // R2

        // eight slices: seeded sparse random vectors
        for (int t = 0; t < 4000; t++) begin
            logic [63:0] a, b, c;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = {$urandom, $urandom};
            req8 = (t % 7 == 0) ? '1 : ~(a & b & c);
            en8  = ($urandom % 10 == 0);
            #1;
            chk(8, req8, en8, code8, grp8, eo8);
            #1;
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule